// File: doc/BRIEF.md
# Processor Status Register Controller

This block keeps the 16-bit processor status word of a 32-bit core. The word holds the four condition flags, a cache-mode flag, a one-shot flag that selects the upper bank of global registers, an interrupt-mode flag, a five-bit floating-point trap enable field and a two-bit rounding-mode field. Software loads the word through a program write port. Instruction events from the pipeline change it on their own: a frame instruction, a taken branch, an interrupt entry, a return and the start of the next instruction.

The block also turns a four-bit global register number from the decoder into a five-bit physical index. When the upper-bank flag is set, numbers 0..15 select registers 16..31. If code in user state names an upper-bank register as its destination, the block stops the register-file write in the same cycle and requests a privilege trap.

Top module: `psr_ctrl`

## Requirements
- R1: After reset, `psr` reads 16'h0000 and no trap is requested.
- R2: A program write (`wr_en`) loads the word on the next clock edge. The fields are C=bit 0, Z=bit 1, N=bit 2, V=bit 3, M=bit 4, H=bit 5, I=bit 7, trap enables=bits 12..8 and rounding mode=bits 14..13. Bits 6 and 15 always read 0, so writing 16'hFFFF gives 16'h7FBF.
- R3: M (bit 4) clears on the edge after `frame_ev`, or after `br_taken` with `br_delayed` low. This clear wins over a program write in the same cycle. A taken delayed branch leaves M unchanged.
- R4: `reg_idx` equals {H, `reg_num`}. With H=1, number 3 maps to index 19, and with H=0 it maps to index 3.
- R5: H (bit 5) clears on the edge after a cycle with `insn_adv` high, unless a program write in that same cycle loads H.
- R6: `priv_trap` and `wr_suppress` are high in the same cycle exactly when `dst_valid` is high, H is 1 and `sup` is 0.
- R7: `irq_entry` sets I (bit 7) on the next edge and saves the prior value of I.
- R8: `ret_ev` without `irq_entry` restores I from the saved copy on the next edge.
- R9: An interrupt entry or a return decides the new I ahead of a program write in the same cycle. The write still loads all the other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Program write strobe |
| wr_data | input | 16 | Program write value |
| frame_ev | input | 1 | Frame instruction executes |
| br_taken | input | 1 | Branch is taken |
| br_delayed | input | 1 | The taken branch is a delayed branch |
| irq_entry | input | 1 | Interrupt entry |
| ret_ev | input | 1 | Return instruction executes |
| insn_adv | input | 1 | First cycle of the next instruction |
| sup | input | 1 | Supervisor state (1) or user state (0) |
| dst_valid | input | 1 | A global register is the destination this cycle |
| reg_num | input | 4 | Decoded global register number |
| psr | output | 16 | Status word |
| reg_idx | output | 5 | Remapped physical register index |
| wr_suppress | output | 1 | Block the register-file write |
| priv_trap | output | 1 | Privilege error trap request |

## Verification
A wrong upper-bank flag shows at once on `reg_idx` and on the trap outputs, because both are combinational on the stored H bit. A missed one-shot clear shows in the first cycle of the following instruction. A lost M clear or a bad interrupt-mode value shows on `psr` one edge after the event. A corrupted saved copy of I stays hidden until the next return, so the bench checks return results after sequences where the saved value differs from the current one.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W   = 16;
  localparam int GNUM_W  = 4;
  localparam int C_BIT   = 0;
  localparam int Z_BIT   = 1;
  localparam int N_BIT   = 2;
  localparam int V_BIT   = 3;
  localparam int M_BIT   = 4;
  localparam int H_BIT   = 5;
  localparam int I_BIT   = 7;
  localparam int FTE_LO  = 8;
  localparam int FTE_W   = 5;
  localparam int FRM_LO  = 13;
  localparam int FRM_W   = 2;

  // Bits held by the field register: everything except I and the reserved bits.
  function automatic logic [PSR_W-1:0] field_mask();
    logic [PSR_W-1:0] m;
    m = '0;
    for (int b = C_BIT; b <= H_BIT; b++) m[b] = 1'b1;
    for (int b = FTE_LO; b < FTE_LO + FTE_W; b++) m[b] = 1'b1;
    for (int b = FRM_LO; b < FRM_LO + FRM_W; b++) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [GNUM_W:0] remap_idx(input logic h, input logic [GNUM_W-1:0] num);
    return {h, num};
  endfunction

  function automatic logic priv_violation(input logic h, input logic s, input logic vld);
    return vld & h & ~s;
  endfunction
endpackage

// File: rtl/psr_field_reg.sv
module psr_field_reg
  import psr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PSR_W-1:0] wr_data,
  input  logic             m_clr,
  input  logic             h_done,
  output logic [PSR_W-1:0] q
);
  localparam logic [PSR_W-1:0] MASK = field_mask();
  logic [PSR_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (h_done) nxt[H_BIT] = 1'b0;
    if (wr_en)  nxt = wr_data & MASK;
    if (m_clr)  nxt[M_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/psr_irq_ctx.sv
module psr_irq_ctx (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_entry,
  input  logic ret_ev,
  input  logic wr_en,
  input  logic wr_i,
  output logic i_q,
  output logic saved_q
);
  logic i_nxt, s_nxt;

  always_comb begin
    i_nxt = i_q;
    s_nxt = saved_q;
    if (irq_entry) begin
      i_nxt = 1'b1;
      s_nxt = i_q;
    end else if (ret_ev) begin
      i_nxt = saved_q;
    end else if (wr_en) begin
      i_nxt = wr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_q     <= 1'b0;
      saved_q <= 1'b0;
    end else begin
      i_q     <= i_nxt;
      saved_q <= s_nxt;
    end
  end
endmodule

// File: rtl/psr_gbl_remap.sv
module psr_gbl_remap
  import psr_pkg::*;
#(
  parameter int NUM_W = GNUM_W
) (
  input  logic             h,
  input  logic             sup,
  input  logic             dst_valid,
  input  logic [NUM_W-1:0] reg_num,
  output logic [NUM_W:0]   reg_idx,
  output logic             violation
);
  always_comb begin
    reg_idx   = {h, reg_num};
    violation = priv_violation(h, sup, dst_valid);
  end
endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PSR_W-1:0]  wr_data,
  input  logic              frame_ev,
  input  logic              br_taken,
  input  logic              br_delayed,
  input  logic              irq_entry,
  input  logic              ret_ev,
  input  logic              insn_adv,
  input  logic              sup,
  input  logic              dst_valid,
  input  logic [GNUM_W-1:0] reg_num,
  output logic [PSR_W-1:0]  psr,
  output logic [GNUM_W:0]   reg_idx,
  output logic              wr_suppress,
  output logic              priv_trap
);
  logic             m_clr_ev;
  logic             h_done_ev;
  logic [PSR_W-1:0] fields_q;
  logic             i_q;
  logic             saved_i;
  logic             violation;

  assign m_clr_ev  = frame_ev | (br_taken & ~br_delayed);
  assign h_done_ev = insn_adv;

  psr_field_reg u_fields (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .m_clr   (m_clr_ev),
    .h_done  (h_done_ev),
    .q       (fields_q)
  );

  psr_irq_ctx u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_entry (irq_entry),
    .ret_ev    (ret_ev),
    .wr_en     (wr_en),
    .wr_i      (wr_data[I_BIT]),
    .i_q       (i_q),
    .saved_q   (saved_i)
  );

  psr_gbl_remap #(.NUM_W(GNUM_W)) u_remap (
    .h         (fields_q[H_BIT]),
    .sup       (sup),
    .dst_valid (dst_valid),
    .reg_num   (reg_num),
    .reg_idx   (reg_idx),
    .violation (violation)
  );

  always_comb begin
    psr        = fields_q;
    psr[I_BIT] = i_q;
  end

  assign wr_suppress = violation;
  assign priv_trap   = violation;
endmodule

// File: rtl/psr_chk.sv
module psr_chk
  import psr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [PSR_W-1:0]  wr_data,
  input logic              irq_entry,
  input logic              ret_ev,
  input logic              insn_adv,
  input logic              sup,
  input logic              dst_valid,
  input logic [GNUM_W-1:0] reg_num,
  input logic [PSR_W-1:0]  psr,
  input logic [GNUM_W:0]   reg_idx,
  input logic              wr_suppress,
  input logic              priv_trap,
  input logic              m_clr_ev,
  input logic              saved_i
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (psr[6] == 1'b0) && (psr[15] == 1'b0)); // R2
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !m_clr_ev && !irq_entry && !ret_ev) |=> psr == ($past(wr_data) & 16'h7FBF)); // R2
  AST_M_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n) m_clr_ev |=> !psr[M_BIT]); // R3
  AST_REMAP_BANK: assert property (@(posedge clk) disable iff (!rst_n) (reg_idx[GNUM_W] == psr[H_BIT]) && (reg_idx[GNUM_W-1:0] == reg_num)); // R4
  AST_H_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n) (insn_adv && !wr_en) |=> !psr[H_BIT]); // R5
  AST_TRAP_USER: assert property (@(posedge clk) disable iff (!rst_n) (dst_valid && !sup && psr[H_BIT]) |-> (priv_trap && wr_suppress)); // R6
  AST_TRAP_NONE: assert property (@(posedge clk) disable iff (!rst_n) (sup || !dst_valid || !psr[H_BIT]) |-> (!priv_trap && !wr_suppress)); // R6
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n) irq_entry |=> (psr[I_BIT] && saved_i == $past(psr[I_BIT]))); // R7
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n) (ret_ev && !irq_entry) |=> psr[I_BIT] == $past(saved_i)); // R8
endmodule

bind psr_ctrl psr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .irq_entry   (irq_entry),
  .ret_ev      (ret_ev),
  .insn_adv    (insn_adv),
  .sup         (sup),
  .dst_valid   (dst_valid),
  .reg_num     (reg_num),
  .psr         (psr),
  .reg_idx     (reg_idx),
  .wr_suppress (wr_suppress),
  .priv_trap   (priv_trap),
  .m_clr_ev    (m_clr_ev),
  .saved_i     (saved_i)
);

// File: tb/tb_psr_ctrl.sv
module tb_psr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, frame_ev, br_taken, br_delayed, irq_entry, ret_ev, insn_adv;
  logic        sup, dst_valid;
  logic [15:0] wr_data;
  logic [3:0]  reg_num;
  logic [15:0] psr;
  logic [4:0]  reg_idx;
  logic        wr_suppress, priv_trap;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  psr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .frame_ev(frame_ev),
    .br_taken(br_taken), .br_delayed(br_delayed), .irq_entry(irq_entry), .ret_ev(ret_ev),
    .insn_adv(insn_adv), .sup(sup), .dst_valid(dst_valid), .reg_num(reg_num),
    .psr(psr), .reg_idx(reg_idx), .wr_suppress(wr_suppress), .priv_trap(priv_trap)
  );

  // Readable value of a written word: bits 6 and 15 always read 0.
  function automatic logic [15:0] readable(input logic [15:0] v);
    logic [15:0] r;
    r = v;
    r[6] = 1'b0;
    r[15] = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_data = '0; frame_ev = 0; br_taken = 0; br_delayed = 0;
    irq_entry = 0; ret_ev = 0; insn_adv = 0; dst_valid = 0;
  endtask

  // Inputs already set; cross one rising edge and return at the next falling edge.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic write(input logic [15:0] v);
    wr_en = 1; wr_data = v;
    step();
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); sup = 1; reg_num = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset psr", psr, 16'h0000);
    check("R1 reset trap", {15'd0, priv_trap}, 16'h0);
  endtask

  task automatic t_write();
    write(16'hFFFF);
    check("R2 all ones", psr, readable(16'hFFFF));
    check("R2 all ones const", psr, 16'h7FBF);
    write(16'h0000);
    check("R2 zero", psr, 16'h0000);
    write(16'h5A35);
    check("R2 pattern", psr, readable(16'h5A35));
    write(16'h0000);
  endtask

  task automatic t_mclr();
    write(16'h0010);
    frame_ev = 1; step();
    check("R3 frame clears M", psr, 16'h0000);
    write(16'h0010);
    br_taken = 1; br_delayed = 1; step();
    check("R3 delayed branch keeps M", psr, 16'h0010);
    br_taken = 1; step();
    check("R3 taken branch clears M", psr, 16'h0000);
    wr_en = 1; wr_data = 16'h001F; frame_ev = 1; step();
    check("R3 clear beats write", psr, 16'h000F);
    write(16'h0000);
  endtask

  task automatic t_remap();
    sup = 1;
    write(16'h0020);
    reg_num = 4'd3; #1;
    check("R4 high bank idx", {11'd0, reg_idx}, 16'd19);
    @(negedge clk);
    insn_adv = 1; step();
    check("R5 H cleared", psr, 16'h0000);
    #1;
    check("R4 low bank idx", {11'd0, reg_idx}, 16'd3);
    write(16'h0020);
    insn_adv = 1; wr_en = 1; wr_data = 16'h0020; step();
    check("R5 write wins over clear", psr, 16'h0020);
    insn_adv = 1; step();
    check("R5 second clear", psr, 16'h0000);
  endtask

  task automatic t_trap();
    write(16'h0020);
    sup = 0; dst_valid = 1; reg_num = 4'd7; #1;
    check("R6 user high dest", {14'd0, priv_trap, wr_suppress}, 16'h3);
    sup = 1; #1;
    check("R6 supervisor ok", {14'd0, priv_trap, wr_suppress}, 16'h0);
    sup = 0; dst_valid = 0; #1;
    check("R6 no dest", {14'd0, priv_trap, wr_suppress}, 16'h0);
    @(negedge clk);
    insn_adv = 1; step();
    sup = 0; dst_valid = 1; #1;
    check("R6 H clear no trap", {14'd0, priv_trap, wr_suppress}, 16'h0);
    @(negedge clk);
    idle(); sup = 1;
  endtask

  task automatic t_irq();
    write(16'h0000);
    irq_entry = 1; step();
    check("R7 irq sets I", psr, 16'h0080);
    write(16'h0080);
    ret_ev = 1; step();
    check("R8 ret restores 0", psr, 16'h0000);
    write(16'h0080);
    irq_entry = 1; step();
    write(16'h0000);
    ret_ev = 1; step();
    check("R8 ret restores 1", psr, 16'h0080);
    write(16'h0000);
    irq_entry = 1; wr_en = 1; wr_data = 16'h0003; step();
    check("R9 irq beats write", psr, 16'h0083);
    ret_ev = 1; wr_en = 1; wr_data = 16'h0084; step();
    check("R9 ret beats write", psr, 16'h0004);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write();
    t_mclr();
    t_remap();
    t_trap();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule